// File: doc/BRIEF.md
# Precision-time event timestamp capture unit

This block sits next to the transmit and receive paths of an Ethernet MAC. Upstream logic strobes start-of-frame for each frame and supplies two pieces of classification: a flag saying the frame matched the precision-time protocol, and the frame's 4-bit message type. From these the block decides by itself whether the frame is a timing event. For an event frame it copies the running time-of-day value into a capture register for that direction and marks a pending status bit. A maskable interrupt then tells software to read the stored time.

Each direction has exactly one capture slot and no queue. If a second event frame arrives in a direction while its slot is still pending, that timestamp cannot be stored. The block keeps the first value and sets a sticky overrun bit, so software knows a timestamp was lost. Software controls the interrupt through two write-one strobes, one that enables sources and one that disables them. It clears a pending bit either by pulsing the read strobe of the capture register or by writing one to the status bit.

In every two-bit field, bit 0 is transmit and bit 1 is receive.

Top module: `ptsu_top`

## Requirements
- R1: After a clock edge with rst_n low, both pending bits, both overrun bits, both enable bits, irq and both capture registers are zero.
- R2: A frame is an event only when its start strobe is high, its protocol-match flag is high and its message type is 0, 1, 2 or 3 (the two upper bits of the 4-bit type are zero). Any other frame leaves the capture registers and the status unchanged.
- R3: Take an event frame whose slot is free. At the clock edge where its start strobe is high, the capture register of that direction stores tod. From the next cycle on, its pending bit reads 1.
- R4: The transmit and receive sides are independent. A capture, clear or overrun in one direction leaves the other direction's capture register, pending bit and overrun bit unchanged.
- R5: Writing int_en_set sets each enable bit written with 1. A bit written with 0 leaves its enable bit unchanged.
- R6: Writing int_dis_set clears each enable bit written with 1. If the same bit is set and disabled in the same cycle, the disable wins.
- R7: irq is high exactly when some direction has both its pending bit and its enable bit set.
- R8: When an event frame arrives in a direction whose pending bit is set and not being cleared in that cycle, the capture register keeps its old value and the overrun bit of that direction becomes 1.
- R9: A pulse on the read strobe of a direction, or a 1 in that bit of stat_clr, clears its pending bit in the next cycle. If a clear and a new event coincide, the new time is captured, pending stays 1 and no overrun is flagged.
- R10: An overrun bit stays set until ovr_clr is written with 1 in that bit. If a new overrun coincides with the clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tod | input | TS_W | Running time-of-day value |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_ptp | input | 1 | Transmit frame matched the timing protocol |
| tx_msg_type | input | MT_W | Transmit frame message type |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ptp | input | 1 | Receive frame matched the timing protocol |
| rx_msg_type | input | MT_W | Receive frame message type |
| tx_stamp_rd | input | 1 | Software read strobe of the transmit capture register |
| rx_stamp_rd | input | 1 | Software read strobe of the receive capture register |
| int_en_set | input | 2 | Write-one interrupt enable (bit0 tx, bit1 rx) |
| int_dis_set | input | 2 | Write-one interrupt disable |
| stat_clr | input | 2 | Write-one clear of the pending bits |
| ovr_clr | input | 2 | Write-one clear of the overrun bits |
| tx_stamp | output | TS_W | Transmit capture register |
| rx_stamp | output | TS_W | Receive capture register |
| stat_pend | output | 2 | Pending bits |
| stat_ovr | output | 2 | Sticky overrun bits |
| int_en | output | 2 | Current interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event that lands in the same cycle as the clear of the previous one in the same direction. A one-cycle shift either way turns a clean capture into a lost timestamp. The bench places the read strobe and the new start strobe on the same clock edge, then checks that the new time replaced the old one and that no overrun bit appeared. It also drives back-to-back events one cycle apart to show that the first value is kept and the overrun bit is set. During that sequence the other direction must stay untouched.

// File: rtl/ptsu_pkg.sv
// Shared constants and helpers for the timestamp capture unit.
// Assumes direction index 0 is transmit and 1 is receive.
package ptsu_pkg;
    localparam int MT_W     = 4;   // message type width
    localparam int N_DIR    = 2;   // transmit and receive
    localparam int DIR_TX   = 0;
    localparam int DIR_RX   = 1;
    localparam int EVT_HI_W = 2;   // upper type bits that must be zero for an event

    // Decide whether a classified frame is a timing event (types 0..3)
    function automatic logic is_event(input logic ptp, input logic [MT_W-1:0] mtype);
        return ptp && (mtype[MT_W-1 -: EVT_HI_W] == '0);
    endfunction
endpackage

// File: rtl/ptsu_slot.sv
// One-direction capture slot: latches tod on an event frame when free,
// flags a sticky overrun when an event finds the slot still pending.
// Assumes sof is a single-cycle strobe and clr/ovr_clr are write pulses.
module ptsu_slot
    import ptsu_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof,
    input  logic            ptp,
    input  logic [MT_W-1:0] mtype,
    input  logic [TS_W-1:0] tod,
    input  logic            clr,
    input  logic            ovr_clr,
    output logic [TS_W-1:0] stamp,
    output logic            pend,
    output logic            ovr
);
    logic cap;
    logic pend_keep;

    // Event detection and the pending state surviving this cycle's clear
    always_comb begin
        cap       = sof && is_event(ptp, mtype);
        pend_keep = pend && !clr;
    end

    // Capture register and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
            pend  <= 1'b0;
        end else if (cap && !pend_keep) begin
            stamp <= tod;
            pend  <= 1'b1;
        end else begin
            pend  <= pend_keep;
        end
    end

    // Sticky overrun: a new loss wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (cap && pend_keep) begin
            ovr <= 1'b1;
        end else if (ovr_clr) begin
            ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/ptsu_irq.sv
// Interrupt mask with separate write-one enable and disable strobes and
// the combined request line. Assumes strobes are single-cycle writes.
module ptsu_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_dis,
    input  logic [N-1:0] pend,
    output logic [N-1:0] en,
    output logic         irq
);
    // Mask register: disable dominates a simultaneous enable
    always_ff @(posedge clk) begin
        if (!rst_n) en <= '0;
        else        en <= (en | en_set) & ~en_dis;
    end

    // Request is any enabled pending source
    always_comb begin
        irq = |(pend & en);
    end
endmodule

// File: rtl/ptsu_top.sv
// Timestamp capture unit top: one capture slot per direction and a shared
// interrupt mask. Bit 0 of every two-bit field is transmit, bit 1 receive.
// Assumes tod is stable around the clock edge and the classification is
// valid in the cycle of the start strobe.
module ptsu_top
    import ptsu_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_W-1:0]     tod,
    input  logic                tx_sof,
    input  logic                tx_ptp,
    input  logic [MT_W-1:0]     tx_msg_type,
    input  logic                rx_sof,
    input  logic                rx_ptp,
    input  logic [MT_W-1:0]     rx_msg_type,
    input  logic                tx_stamp_rd,
    input  logic                rx_stamp_rd,
    input  logic [N_DIR-1:0]    int_en_set,
    input  logic [N_DIR-1:0]    int_dis_set,
    input  logic [N_DIR-1:0]    stat_clr,
    input  logic [N_DIR-1:0]    ovr_clr,
    output logic [TS_W-1:0]     tx_stamp,
    output logic [TS_W-1:0]     rx_stamp,
    output logic [N_DIR-1:0]    stat_pend,
    output logic [N_DIR-1:0]    stat_ovr,
    output logic [N_DIR-1:0]    int_en,
    output logic                irq
);
    logic [N_DIR-1:0]           sof_v;
    logic [N_DIR-1:0]           ptp_v;
    logic [N_DIR-1:0][MT_W-1:0] mt_v;
    logic [N_DIR-1:0]           rd_v;
    logic [N_DIR-1:0][TS_W-1:0] stamp_v;

    // Gather per-direction inputs into indexed vectors
    always_comb begin
        sof_v[DIR_TX] = tx_sof;       sof_v[DIR_RX] = rx_sof;
        ptp_v[DIR_TX] = tx_ptp;       ptp_v[DIR_RX] = rx_ptp;
        mt_v[DIR_TX]  = tx_msg_type;  mt_v[DIR_RX]  = rx_msg_type;
        rd_v[DIR_TX]  = tx_stamp_rd;  rd_v[DIR_RX]  = rx_stamp_rd;
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        ptsu_slot #(.TS_W(TS_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .sof     (sof_v[d]),
            .ptp     (ptp_v[d]),
            .mtype   (mt_v[d]),
            .tod     (tod),
            .clr     (rd_v[d] | stat_clr[d]),
            .ovr_clr (ovr_clr[d]),
            .stamp   (stamp_v[d]),
            .pend    (stat_pend[d]),
            .ovr     (stat_ovr[d])
        );
    end

    ptsu_irq #(.N(N_DIR)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_set (int_en_set),
        .en_dis (int_dis_set),
        .pend   (stat_pend),
        .en     (int_en),
        .irq    (irq)
    );

    // Present capture registers on the named outputs
    always_comb begin
        tx_stamp = stamp_v[DIR_TX];
        rx_stamp = stamp_v[DIR_RX];
    end
endmodule

// File: rtl/ptsu_chk.sv
// Property checker for ptsu_top, attached by bind below.
module ptsu_chk
    import ptsu_pkg::*;
#(
    parameter int TS_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic [TS_W-1:0]     tod,
    input logic                tx_sof,
    input logic                tx_ptp,
    input logic [MT_W-1:0]     tx_msg_type,
    input logic                rx_sof,
    input logic                tx_stamp_rd,
    input logic [N_DIR-1:0]    int_dis_set,
    input logic [N_DIR-1:0]    stat_clr,
    input logic [N_DIR-1:0]    ovr_clr,
    input logic [TS_W-1:0]     tx_stamp,
    input logic [TS_W-1:0]     rx_stamp,
    input logic [N_DIR-1:0]    stat_pend,
    input logic [N_DIR-1:0]    stat_ovr,
    input logic [N_DIR-1:0]    int_en,
    input logic                irq
);
    logic tx_evt;
    logic tx_clr;
    assign tx_evt = tx_sof && tx_ptp && (tx_msg_type < 4'd4);
    assign tx_clr = tx_stamp_rd || stat_clr[0];

    // R3
    tx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt && !(stat_pend[0] && !tx_clr) |=> stat_pend[0] && tx_stamp == $past(tod));

    // R2
    tx_nonevent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_evt && !stat_pend[0] |=> !stat_pend[0] && $stable(tx_stamp));

    // R8
    tx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt && stat_pend[0] && !tx_clr |=> stat_ovr[0] && $stable(tx_stamp));

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ovr[1] && !ovr_clr[1] |=> stat_ovr[1]);

    // R4
    rx_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sof |=> $stable(rx_stamp));

    // R6
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_dis_set[0] |=> !int_en[0]);

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_pend & int_en) == '0) |-> !irq);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_pend & int_en) != '0) |-> irq);
endmodule

bind ptsu_top ptsu_chk #(.TS_W(TS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tod         (tod),
    .tx_sof      (tx_sof),
    .tx_ptp      (tx_ptp),
    .tx_msg_type (tx_msg_type),
    .rx_sof      (rx_sof),
    .tx_stamp_rd (tx_stamp_rd),
    .int_dis_set (int_dis_set),
    .stat_clr    (stat_clr),
    .ovr_clr     (ovr_clr),
    .tx_stamp    (tx_stamp),
    .rx_stamp    (rx_stamp),
    .stat_pend   (stat_pend),
    .stat_ovr    (stat_ovr),
    .int_en      (int_en),
    .irq         (irq)
);

// File: tb/tb_ptsu_top.sv
// Directed bench for ptsu_top: one task per scenario.
module tb_ptsu_top;
    localparam int TS_W = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TS_W-1:0] tod = 64'd1000;
    logic            tx_sof = 0, tx_ptp = 0, rx_sof = 0, rx_ptp = 0;
    logic [3:0]      tx_msg_type = 0, rx_msg_type = 0;
    logic            tx_stamp_rd = 0, rx_stamp_rd = 0;
    logic [1:0]      int_en_set = 0, int_dis_set = 0, stat_clr = 0, ovr_clr = 0;
    logic [TS_W-1:0] tx_stamp, rx_stamp;
    logic [1:0]      stat_pend, stat_ovr, int_en;
    logic            irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) tod <= tod + 64'd8;

    ptsu_top #(.TS_W(TS_W)) dut (
        .clk(clk), .rst_n(rst_n), .tod(tod),
        .tx_sof(tx_sof), .tx_ptp(tx_ptp), .tx_msg_type(tx_msg_type),
        .rx_sof(rx_sof), .rx_ptp(rx_ptp), .rx_msg_type(rx_msg_type),
        .tx_stamp_rd(tx_stamp_rd), .rx_stamp_rd(rx_stamp_rd),
        .int_en_set(int_en_set), .int_dis_set(int_dis_set),
        .stat_clr(stat_clr), .ovr_clr(ovr_clr),
        .tx_stamp(tx_stamp), .rx_stamp(rx_stamp),
        .stat_pend(stat_pend), .stat_ovr(stat_ovr),
        .int_en(int_en), .irq(irq)
    );

    task automatic check(input string req, input logic [TS_W-1:0] act, input logic [TS_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge, then back to the falling edge with strobes released
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        tx_sof = 0; rx_sof = 0; tx_stamp_rd = 0; rx_stamp_rd = 0;
        int_en_set = 0; int_dis_set = 0; stat_clr = 0; ovr_clr = 0;
    endtask

    task automatic tx_frame(input logic ptp, input logic [3:0] mt);
        tx_sof = 1; tx_ptp = ptp; tx_msg_type = mt;
    endtask

    task automatic rx_frame(input logic ptp, input logic [3:0] mt);
        rx_sof = 1; rx_ptp = ptp; rx_msg_type = mt;
    endtask

    task automatic clear_all();
        stat_clr = 2'b11; ovr_clr = 2'b11; int_dis_set = 2'b11;
        tick();
    endtask

    task automatic t_reset();
        check("R1 pend", stat_pend, 0);
        check("R1 ovr", stat_ovr, 0);
        check("R1 en", int_en, 0);
        check("R1 irq", irq, 0);
        check("R1 tx_stamp", tx_stamp, 0);
        check("R1 rx_stamp", rx_stamp, 0);
    endtask

    task automatic t_classify();
        logic [TS_W-1:0] t;
        tx_frame(1, 4'd8); tick();          // general message type
        check("R2 type8 ignored", stat_pend, 0);
        tx_frame(0, 4'd0); tick();          // no protocol match
        check("R2 nomatch ignored", stat_pend, 0);
        tx_frame(1, 4'd4); tick();          // first non-event type
        check("R2 type4 ignored", stat_pend, 0);
        check("R2 stamp untouched", tx_stamp, 0);
        t = tod; tx_frame(1, 4'd3); tick();
        check("R3 tx pend", stat_pend, 2'b01);
        check("R3 tx stamp", tx_stamp, t);
        check("R4 rx untouched", rx_stamp, 0);
        t = tod; rx_frame(1, 4'd0); tick();
        check("R3 rx stamp", rx_stamp, t);
        check("R4 both pend", stat_pend, 2'b11);
        clear_all();
    endtask

    task automatic t_irq();
        logic [TS_W-1:0] t;
        int_en_set = 2'b01; tick();
        check("R5 enable tx", int_en, 2'b01);
        int_en_set = 2'b00; tick();
        check("R5 zero write no effect", int_en, 2'b01);
        check("R7 no pend no irq", irq, 0);
        t = tod; rx_frame(1, 4'd1); tick();
        check("R7 masked rx no irq", irq, 0);
        check("R3 rx stamp", rx_stamp, t);
        tx_frame(1, 4'd2); tick();
        check("R7 enabled tx irq", irq, 1);
        int_dis_set = 2'b01; tick();
        check("R6 disable tx", int_en, 2'b00);
        check("R7 irq after disable", irq, 0);
        int_en_set = 2'b10; int_dis_set = 2'b10; tick();
        check("R6 disable wins", int_en, 2'b00);
        int_en_set = 2'b10; tick();
        check("R7 rx irq", irq, 1);
        rx_stamp_rd = 1; tick();
        check("R9 rx read clears", stat_pend, 2'b01);
        check("R7 irq drops", irq, 0);
        clear_all();
    endtask

    task automatic t_overrun();
        logic [TS_W-1:0] t, t2;
        t = tod; tx_frame(1, 4'd0); tick();
        tx_frame(1, 4'd2); tick();
        check("R8 first kept", tx_stamp, t);
        check("R8 ovr set", stat_ovr, 2'b01);
        check("R4 rx ovr clear", stat_ovr[1], 0);
        tick();
        check("R10 sticky", stat_ovr, 2'b01);
        stat_clr = 2'b01; tick();
        check("R9 stat_clr clears", stat_pend, 0);
        check("R10 pend clear keeps ovr", stat_ovr, 2'b01);
        tx_frame(1, 4'd1); tick();
        t = tx_stamp;
        t2 = tod; tx_stamp_rd = 1; tx_frame(1, 4'd3); tick();
        check("R9 coincident capture", tx_stamp, t2);
        check("R9 coincident pend", stat_pend, 2'b01);
        ovr_clr = 2'b01; tick();
        check("R10 ovr cleared", stat_ovr, 0);
        tx_frame(1, 4'd0); ovr_clr = 2'b01; tick();
        check("R10 new loss wins", stat_ovr, 2'b01);
        clear_all();
        rx_frame(1, 4'd0); tick();
        t = rx_stamp; rx_stamp_rd = 1; rx_frame(1, 4'd1); tick();
        check("R9 rx coincident no ovr", stat_ovr, 0);
        clear_all();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        tick();
        t_classify();
        t_irq();
        t_overrun();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule